// File: doc/BRIEF.md
# Selectable-Order Burst Address Counter

This block produces the low-order address bits of a four-beat burst for a synchronous pipelined cache memory. A burst begins when either of two independent address strobes (one meant for a processor, one for a cache controller) is sampled high at a rising clock edge. At that edge the block captures the 2-bit starting address and clears its internal beat count. After that, each clock edge at which the advance input is high moves the burst on by one beat. The beat count wraps, so a burst visits all four addresses and then starts over.

A static order-select input picks one of two address orders. In the interleaved order, the output is the captured start address XORed with the beat count. In the linear order, the output is the start address plus the beat count, modulo four. All inputs are sampled on the rising clock edge, and the burst address comes from a register. A synchronous active-high reset clears everything to zero. The upper address bits, the storage array and the data path are handled elsewhere.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next `burst_addr` is 0, and the captured start and the beat count both become 0.
- R2: When `strobe_cpu` is high at a rising edge, `burst_addr` after that edge equals the `start_addr` sampled at that edge, and the beat count restarts at 0.
- R3: When `strobe_ctl` is high at a rising edge, it loads in the same way as `strobe_cpu`, whether or not `strobe_cpu` is also high.
- R4: With `order_sel` = 1 (interleaved), after k advance edges since the load, `burst_addr` equals start XOR (k mod 4). For example, start 1 gives 1, 0, 3, 2.
- R5: With `order_sel` = 0 (linear), after k advance edges since the load, `burst_addr` equals (start + k) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R6: The fourth advance after a load returns `burst_addr` to the start address, and the sequence then repeats.
- R7: When a strobe and `advance` are both high at the same edge, the strobe wins: the new start address is loaded and no beat is taken.
- R8: At an edge with no strobe and `advance` low, `burst_addr` and the beat count stay unchanged. The next advance continues from the held beat.
- R9: A reset in the middle of a burst clears the beat count. A later advance with no new load then yields `burst_addr` = 1 in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_cpu | input | 1 | Processor-side burst start strobe |
| strobe_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step the burst one beat |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| start_addr | input | BEAT_BITS | Starting low address of the burst |
| burst_addr | output | BEAT_BITS | Registered current burst address |

## Verification
The step assertions assume that `order_sel` is held for the whole burst. The output at each edge is formed with the order in force at that edge, so changing the order mid-burst would reinterpret the beat count in a different order. The stimulus only changes `order_sel` in a cycle where a strobe loads a new burst. It keeps every input stable around the rising edge by driving on the falling edge. Reset is applied only as a whole-cycle pulse, and at least one clock edge sees it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  logic [BEAT_BITS-1:0] base,
  input  logic [BEAT_BITS-1:0] beat,
  input  burst_order_e         order,
  output logic [BEAT_BITS-1:0] addr
);

  logic [BEAT_BITS-1:0] xor_addr;
  logic [BEAT_BITS-1:0] sum_addr;

  // interleaved order: one XOR per address bit
  for (genvar b = 0; b < BEAT_BITS; b++) begin : g_xor
    assign xor_addr[b] = base[b] ^ beat[b];
  end

  // linear order: modulo-2^BEAT_BITS add, the carry out drops
  assign sum_addr = base + beat;

  always_comb begin
    case (order)
      ORDER_INTERLEAVED: addr = xor_addr;
      default:           addr = sum_addr;
    endcase
  end

endmodule

// File: rtl/burst_beat_state.sv
module burst_beat_state #(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 step,
  input  logic [BEAT_BITS-1:0] load_addr,
  output logic [BEAT_BITS-1:0] base_nxt,
  output logic [BEAT_BITS-1:0] beat_nxt
);

  logic [BEAT_BITS-1:0] base_q;
  logic [BEAT_BITS-1:0] beat_q;

  // a load beats a step; with neither, the state holds
  always_comb begin
    base_nxt = base_q;
    beat_nxt = beat_q;
    if (load) begin
      base_nxt = load_addr;
      beat_nxt = '0;
    end else if (step) begin
      beat_nxt = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      base_q <= base_nxt;
      beat_q <= beat_nxt;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe_cpu,
  input  logic                 strobe_ctl,
  input  logic                 advance,
  input  logic                 order_sel,
  input  logic [BEAT_BITS-1:0] start_addr,
  output logic [BEAT_BITS-1:0] burst_addr
);

  logic                 load;
  logic [BEAT_BITS-1:0] base_nxt;
  logic [BEAT_BITS-1:0] beat_nxt;
  logic [BEAT_BITS-1:0] addr_nxt;
  burst_order_e         order;

  assign load  = strobe_cpu | strobe_ctl;
  assign order = burst_order_e'(order_sel);

  burst_beat_state #(.BEAT_BITS(BEAT_BITS)) u_state (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (advance),
    .load_addr (start_addr),
    .base_nxt  (base_nxt),
    .beat_nxt  (beat_nxt)
  );

  burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
    .base  (base_nxt),
    .beat  (beat_nxt),
    .order (order),
    .addr  (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) burst_addr <= '0;
    else     burst_addr <= addr_nxt;
  end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int BEAT_BITS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 strobe_cpu,
  input logic                 strobe_ctl,
  input logic                 advance,
  input logic                 order_sel,
  input logic [BEAT_BITS-1:0] start_addr,
  input logic [BEAT_BITS-1:0] burst_addr
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> burst_addr == '0);

  assert_cpu_load_R2: assert property (@(posedge clk) disable iff (rst)
    strobe_cpu |=> burst_addr == $past(start_addr));

  assert_ctl_load_R3: assert property (@(posedge clk) disable iff (rst)
    strobe_ctl |=> burst_addr == $past(start_addr));

  assert_il_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu && !strobe_ctl && advance && order_sel)
      |=> $countones(burst_addr ^ $past(burst_addr)) != 0);

  assert_lin_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu && !strobe_ctl && advance && !order_sel)
      |=> burst_addr == BEAT_BITS'($past(burst_addr) + 1'b1));

  assert_priority_R7: assert property (@(posedge clk) disable iff (rst)
    ((strobe_cpu || strobe_ctl) && advance) |=> burst_addr == $past(start_addr));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu && !strobe_ctl && !advance) |=> $stable(burst_addr));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.BEAT_BITS(BEAT_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strobe_cpu (strobe_cpu),
  .strobe_ctl (strobe_ctl),
  .advance    (advance),
  .order_sel  (order_sel),
  .start_addr (start_addr),
  .burst_addr (burst_addr)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_cpu = 1'b0;
  logic       strobe_ctl = 1'b0;
  logic       advance = 1'b0;
  logic       order_sel = 1'b0;
  logic [1:0] start_addr = 2'd0;
  logic [1:0] burst_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.BEAT_BITS(2)) i_burst_addr_gen (
    .clk        (clk),
    .rst        (rst),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .order_sel  (order_sel),
    .start_addr (start_addr),
    .burst_addr (burst_addr)
  );

  function automatic logic [1:0] expect_addr(input logic il, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return il ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    n_cmp++;
    if (burst_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: burst_addr=%0d expected=%0d", req, burst_addr, exp);
    end
  endtask

  // drive on a falling edge, return on the next falling edge (one rising edge later)
  task automatic apply(input logic r, input logic pc, input logic pt, input logic adv, input logic [1:0] a);
    rst = r; strobe_cpu = pc; strobe_ctl = pt; advance = adv; start_addr = a;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    apply(1, 0, 0, 0, 2'd3);
    apply(1, 0, 0, 0, 2'd3);
    check("R1", 2'd0);

    // exhaustive: order x strobe source x start address
    for (int m = 0; m < 2; m++) begin
      for (int src = 0; src < 3; src++) begin
        for (int s = 0; s < 4; s++) begin
          order_sel = m[0];
          apply(0, src != 1, src != 0, 0, 2'(s));
          check(src == 0 ? "R2" : "R3", 2'(s));
          for (int k = 1; k <= 6; k++) begin
            apply(0, 0, 0, 1, 2'(~s));
            check(k == 4 ? "R6" : (m == 1 ? "R4" : "R5"), expect_addr(m[0], 2'(s), k));
            if (k == 2) begin
              apply(0, 0, 0, 0, 2'(~s));
              check("R8", expect_addr(m[0], 2'(s), k));
            end
          end
        end
      end
    end

    // strobe together with advance, mid-burst
    for (int m = 0; m < 2; m++) begin
      order_sel = m[0];
      apply(0, 1, 0, 0, 2'd2);
      apply(0, 0, 0, 1, 2'd0);
      apply(0, 0, 1, 1, 2'd1);
      check("R7", 2'd1);
      apply(0, 0, 0, 1, 2'd0);
      check("R7", expect_addr(m[0], 2'd1, 1));
    end

    // reset mid-burst clears the beat
    for (int m = 0; m < 2; m++) begin
      order_sel = m[0];
      apply(0, 1, 0, 0, 2'd3);
      apply(0, 0, 0, 1, 2'd0);
      apply(0, 0, 0, 1, 2'd0);
      apply(1, 0, 0, 0, 2'd0);
      check("R1", 2'd0);
      apply(0, 0, 0, 1, 2'd2);
      check("R9", 2'd1);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule